// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Word Writes

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into banks of up to 32. For each bank it keeps an output value latch, a direction word, an output-enable word and an interrupt mask. It also provides a read-only word of synchronised pin levels. Software reaches these through a single-cycle register port: a word address, a write strobe, write data, and read data that is valid in the same cycle. Each pin has three pad-side signals: a drive value, a drive enable and a sampled input.

The output latch can be written as a full word. It can also be written one half at a time through two masked ports per bank. In a masked write, the upper 16 bits of the data word select which of the lower 16 bits land in the latch, so a single pin changes without a read-modify-write. By default one bank is narrower than the rest. Its missing upper pins read as zero and cannot be written. The pads are numbered contiguously across the banks.

Top module: `gpio_banked`

## Requirements
- R1: While reset is asserted and after it is released, every latch, direction, output-enable and interrupt-mask bit is 0, so `pad_out` and `pad_oe` are all zero.
- R2: The word address is {bank index, 3-bit register code}. A write to code 0 (low masked port) treats bits 31:16 as a mask for bank pins 15:0. Where a mask bit is 0, the latch bit takes data bit [i]. Where a mask bit is 1, the latch bit keeps its value.
- R3: A write to code 1 (high masked port) applies the same mask rule to bank pins 31:16, with mask bit 16+i and data bit i controlling pin 16+i.
- R4: A write to code 2 loads the whole latch from write data, and a read of code 2 returns the latch rather than the pin levels.
- R5: `pad_out` mirrors the latch bit of each pin. `pad_oe` of a pin is 1 only when both its direction bit (code 4, 1 = output) and its enable bit (code 5) are 1.
- R6: Code 3 is read-only and returns the pin levels after a two-flop synchroniser. A level present before clock edge n is readable after edge n+1 and not after edge n alone.
- R7: Code 6 is the interrupt mask. Writing a 1 sets the matching mask bit, writing a 0 leaves it unchanged, and a read returns the mask.
- R8: With the defaults, bank 1 has 22 pins, covering pads 32 to 53, and bank 2 starts at pad 54. The unimplemented bits 31:22 of bank 1 read as zero and ignore writes.
- R9: Code 7, and any bank index at or beyond the bank count, reads as zero. Writes to those addresses change no state.
- R10: A read of code 0 or code 1 returns the matching latch half in bits 15:0, with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address: bank index above a 3-bit register code |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, same cycle |
| pad_in | input | TOTAL_PINS | Sampled pin levels |
| pad_out | output | TOTAL_PINS | Pin drive values |
| pad_oe | output | TOTAL_PINS | Pin drive enables |

## Verification
The bench builds the block with its defaults: four banks, bank 1 narrowed to 22 pins, and a 6-bit address. With this setup, the narrow bank's zeroed upper bits are reachable, and so is the pad boundary where bank 2 starts at pad 54. The spare address bit also creates bank indices 4 to 7, which exist in no bank, so writes and reads outside the map can be tested. Masked writes use mixed mask patterns on both halves, and the synchroniser delay is checked one cycle before and one cycle after the level appears.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int SLOT_PINS = 32;
  localparam int HALF_PINS = 16;
  localparam int REG_BITS  = 3;

  typedef enum logic [REG_BITS-1:0] {
    REG_MLO   = 3'd0,
    REG_MHI   = 3'd1,
    REG_DATA  = 3'd2,
    REG_LEVEL = 3'd3,
    REG_DIR   = 3'd4,
    REG_OE    = 3'd5,
    REG_IMASK = 3'd6,
    REG_RSVD  = 3'd7
  } gpio_reg_e;

  function automatic int bank_width(int b, int narrow_idx, int narrow_w);
    return (b == narrow_idx) ? narrow_w : SLOT_PINS;
  endfunction

  function automatic int bank_base(int b, int narrow_idx, int narrow_w);
    return b * SLOT_PINS - ((b > narrow_idx) ? (SLOT_PINS - narrow_w) : 0);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] s1_q;
  logic [WIDTH-1:0] s2_q;
  logic [1:0]       age_q;
  logic [1:0]       age_d;

  always_comb begin
    age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      age_q <= '0;
    end else begin
      s1_q  <= d;
      s2_q  <= s1_q;
      age_q <= age_d;
    end
  end

  assign q = s2_q;

  // R6
  sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  gpio_reg_e        reg_sel,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  localparam logic [31:0] WMASK = 32'hFFFF_FFFF >> (SLOT_PINS - WIDTH);

  logic [WIDTH-1:0] latch_q, latch_d;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] oe_q, oe_d;
  logic [WIDTH-1:0] imask_q, imask_d;
  logic [WIDTH-1:0] level;
  logic             latch_en, dir_en, oe_en, imask_en;

  logic [31:0] latch_x, dir_x, oe_x, imask_x, level_x, latch_nx;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (level)
  );

  always_comb begin
    latch_x = '0;
    dir_x   = '0;
    oe_x    = '0;
    imask_x = '0;
    level_x = '0;
    latch_x[WIDTH-1:0] = latch_q;
    dir_x[WIDTH-1:0]   = dir_q;
    oe_x[WIDTH-1:0]    = oe_q;
    imask_x[WIDTH-1:0] = imask_q;
    level_x[WIDTH-1:0] = level;
  end

  // next state
  always_comb begin
    latch_nx = latch_x;
    case (reg_sel)
      REG_DATA: latch_nx = wdata;
      REG_MLO: begin
        for (int i = 0; i < HALF_PINS; i++) begin
          if (!wdata[HALF_PINS+i]) latch_nx[i] = wdata[i];
        end
      end
      REG_MHI: begin
        for (int i = 0; i < HALF_PINS; i++) begin
          if (!wdata[HALF_PINS+i]) latch_nx[HALF_PINS+i] = wdata[i];
        end
      end
      default: latch_nx = latch_x;
    endcase
    latch_d  = latch_nx[WIDTH-1:0];
    latch_en = we && (reg_sel == REG_DATA || reg_sel == REG_MLO || reg_sel == REG_MHI);
    dir_d    = wdata[WIDTH-1:0];
    dir_en   = we && (reg_sel == REG_DIR);
    oe_d     = wdata[WIDTH-1:0];
    oe_en    = we && (reg_sel == REG_OE);
    imask_d  = imask_q | wdata[WIDTH-1:0];
    imask_en = we && (reg_sel == REG_IMASK);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      oe_q    <= '0;
      imask_q <= '0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (dir_en)   dir_q   <= dir_d;
      if (oe_en)    oe_q    <= oe_d;
      if (imask_en) imask_q <= imask_d;
    end
  end

  // read mux
  always_comb begin
    case (reg_sel)
      REG_MLO:   rdata = {16'h0, latch_x[15:0]};
      REG_MHI:   rdata = {16'h0, latch_x[31:16]};
      REG_DATA:  rdata = latch_x;
      REG_LEVEL: rdata = level_x;
      REG_DIR:   rdata = dir_x;
      REG_OE:    rdata = oe_x;
      REG_IMASK: rdata = imask_x;
      default:   rdata = '0;
    endcase
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q & oe_q;

  // R2
  mlo_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && reg_sel == REG_MLO) |=>
      (((latch_x[15:0] ^ $past(latch_x[15:0])) & $past(wdata[31:16])) == 16'h0));

  // R3
  mhi_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && reg_sel == REG_MHI) |=>
      (((latch_x[31:16] ^ $past(latch_x[31:16])) & $past(wdata[31:16])) == 16'h0));

  // R4
  data_full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && reg_sel == REG_DATA) |=> (latch_x == ($past(wdata) & WMASK)));

  // R7
  imask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((imask_x & $past(imask_x)) == $past(imask_x)));

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int NARROW_BANK = 1,
  parameter int NARROW_W    = 22,
  parameter int ADDR_W      = 6,
  localparam int TOTAL_PINS = NUM_BANKS * SLOT_PINS
                              - ((NARROW_BANK < NUM_BANKS) ? (SLOT_PINS - NARROW_W) : 0)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [TOTAL_PINS-1:0] pad_in,
  output logic [TOTAL_PINS-1:0] pad_out,
  output logic [TOTAL_PINS-1:0] pad_oe
);

  localparam int BIDX_W = ADDR_W - REG_BITS;

  logic              rst_meta_q, rst_sync_n;
  logic [BIDX_W-1:0] bank_idx;
  gpio_reg_e         reg_sel;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic              addr_undef;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign bank_idx = bus_addr[ADDR_W-1:REG_BITS];
  assign reg_sel  = gpio_reg_e'(bus_addr[REG_BITS-1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W    = bank_width(b, NARROW_BANK, NARROW_W);
    localparam int BASE = bank_base(b, NARROW_BANK, NARROW_W);

    assign bank_hit[b] = (bank_idx == BIDX_W'(b));

    gpio_bank #(.WIDTH(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .we      (bus_we && bank_hit[b]),
      .reg_sel (reg_sel),
      .wdata   (bus_wdata),
      .rdata   (bank_rd[b]),
      .pad_in  (pad_in[BASE+W-1:BASE]),
      .pad_out (pad_out[BASE+W-1:BASE]),
      .pad_oe  (pad_oe[BASE+W-1:BASE])
    );
  end

  assign addr_undef = (reg_sel == REG_RSVD) || !(|bank_hit);

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) bus_rdata = bank_rd[b];
    end
  end

  // R9
  undef_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && addr_undef) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

// File: tb/gpio_banked_tb.sv
`timescale 1ns/1ps
module gpio_banked_tb;

  localparam int NP = 118;
  localparam int NV = 26;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int  nvec = 0;
  int  nerr = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_banked u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  // {write, req, addr, wdata, expected read}
  localparam logic [74:0] VECS [NV] = '{
    {1'b1, 4'd4,  6'h02, 32'h1234_5678, 32'h0},          // R4 full load
    {1'b0, 4'd4,  6'h02, 32'h0,         32'h1234_5678},  // R4
    {1'b1, 4'd2,  6'h00, 32'hFF00_00AB, 32'h0},          // R2 low masked
    {1'b0, 4'd2,  6'h02, 32'h0,         32'h1234_56AB},  // R2
    {1'b1, 4'd3,  6'h01, 32'h0FFF_F000, 32'h0},          // R3 high masked
    {1'b0, 4'd3,  6'h02, 32'h0,         32'hF234_56AB},  // R3
    {1'b0, 4'd10, 6'h00, 32'h0,         32'h0000_56AB},  // R10
    {1'b0, 4'd10, 6'h01, 32'h0,         32'h0000_F234},  // R10
    {1'b1, 4'd5,  6'h14, 32'hFFFF_0000, 32'h0},          // R5 bank2 dir
    {1'b0, 4'd5,  6'h14, 32'h0,         32'hFFFF_0000},  // R5
    {1'b1, 4'd7,  6'h16, 32'h0000_00F0, 32'h0},          // R7 set
    {1'b1, 4'd7,  6'h16, 32'h0000_0000, 32'h0},          // R7 zeros ignored
    {1'b0, 4'd7,  6'h16, 32'h0,         32'h0000_00F0},  // R7
    {1'b1, 4'd7,  6'h16, 32'h0000_000F, 32'h0},          // R7
    {1'b0, 4'd7,  6'h16, 32'h0,         32'h0000_00FF},  // R7
    {1'b0, 4'd9,  6'h07, 32'h0,         32'h0},          // R9 code 7
    {1'b1, 4'd8,  6'h0A, 32'hFFFF_FFFF, 32'h0},          // R8 narrow bank
    {1'b0, 4'd8,  6'h0A, 32'h0,         32'h003F_FFFF},  // R8
    {1'b1, 4'd8,  6'h09, 32'h0000_0000, 32'h0},          // R8 high half clear
    {1'b0, 4'd8,  6'h0A, 32'h0,         32'h0000_FFFF},  // R8
    {1'b0, 4'd10, 6'h08, 32'h0,         32'h0000_FFFF},  // R10
    {1'b0, 4'd10, 6'h09, 32'h0,         32'h0},          // R10
    {1'b1, 4'd9,  6'h22, 32'h0000_0000, 32'h0},          // R9 bank 4 absent
    {1'b1, 4'd9,  6'h07, 32'h0000_0000, 32'h0},          // R9
    {1'b0, 4'd9,  6'h02, 32'h0,         32'hF234_56AB},  // R9 bank0 untouched
    {1'b0, 4'd9,  6'h22, 32'h0,         32'h0}           // R9 absent reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", pad_out[31:0] | pad_out[63:32] | pad_out[95:64] | 32'(pad_out[117:96]), 32'h0);
    chk("R1", pad_oe[31:0] | pad_oe[63:32] | pad_oe[95:64] | 32'(pad_oe[117:96]), 32'h0);
    rd("R1", 6'h02, 32'h0);
    rd("R1", 6'h1E, 32'h0);
    rd("R1", 6'h16, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k][74]) wr(VECS[k][69:64], VECS[k][63:32]);
      else rd($sformatf("R%0d", VECS[k][73:70]), VECS[k][69:64], VECS[k][31:0]);
    end

    // R5 / R8 pad mapping
    chk("R5", pad_out[31:0], 32'hF234_56AB);
    chk("R8", 32'(pad_out[53:32]), 32'h0000_FFFF);
    chk("R8", pad_out[85:54], 32'h0);
    wr(6'h04, 32'h0000_FFFF);
    wr(6'h05, 32'h00FF_00FF);
    chk("R5", pad_oe[31:0], 32'h0000_00FF);
    wr(6'h0D, 32'hFFFF_FFFF);
    chk("R5", 32'(pad_oe[53:32]), 32'h0);
    wr(6'h1D, 32'hFFFF_FFFF);
    chk("R5", pad_oe[117:86], 32'h0);

    // R6 synchroniser lag
    @(negedge clk);
    pad_in[53:32]  = 22'h2A_AAAA;
    pad_in[117:86] = 32'hC0DE_0001;
    @(negedge clk);
    rd("R6", 6'h0B, 32'h0);
    @(negedge clk);
    rd("R6", 6'h0B, 32'h002A_AAAA);
    rd("R6", 6'h1B, 32'hC0DE_0001);
    rd("R6", 6'h02, 32'hF234_56AB);

    // R1 mask cleared by a second reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", pad_out[31:0], 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R1", 6'h16, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule